// File: doc/BRIEF.md
# Shadow Return-Address Checker

This block watches instructions as they leave the execute stage of a 32-bit in-order pipeline. For each instruction it receives the raw opcode word, an annul flag, the instruction's PC and the jump target computed in execute. A function call stores the caller's PC on a small private stack that software cannot reach. A function return takes the newest stored PC and compares the target with the address a normal return would use. If they differ, the block raises a one-cycle exception pulse toward the recovery logic. A return address overwritten in the program stack is caught this way before the corrupted return completes.

The block also drives a level that is high while execution sits in the outermost routine, for checkpoint control. A sticky flag reports a call that arrived while the shadow stack was full.

Top module: `retaddr_shadow_chk`

## Requirements
- R1: After reset the shadow stack is empty, `outer_lvl_o` is 1, and `ret_fault_o` and `stk_ovf_o` are 0.
- R2: The opcode is decoded as follows. bits[31:30]=01 is a call. bits[31:30]=10 with bits[24:19]=111000 is an indirect jump; its bits[29:25] are the destination register. Destination 15 makes it a call, and any other destination makes it a return. Every other opcode leaves the stack and all outputs unchanged.
- R3: A call that is not annulled, arriving while the stack is not full, pushes `ex_pc_i` as the new top entry.
- R4: A return that is not annulled, arriving while the stack is not empty, pops the top entry. It compares `ex_tgt_i` with the popped PC plus 8. When they are equal, `ret_fault_o` stays 0.
- R5: When the comparison of R4 fails, `ret_fault_o` is 1 for the clock cycle after the edge that sampled the return. Back-to-back faulting returns give back-to-back pulses.
- R6: An instruction with `ex_annul_i`=1 causes no push, no pop, no comparison and no change of any output.
- R7: `outer_lvl_o` falls when a call is pushed onto an empty stack. It rises when a pop empties the stack.
- R8: A call arriving while the stack holds DEPTH entries stores nothing and sets `stk_ovf_o`. That flag stays 1 until reset. The stored entries stay intact.
- R9: A return that is not annulled, arriving while the stack is empty, gives a `ret_fault_o` pulse and leaves the stack empty.
- R10: Returns pop entries in last-in first-out order across nested calls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ex_insn_i | input | 32 | Opcode word leaving execute |
| ex_annul_i | input | 1 | Instruction is annulled and must be ignored |
| ex_pc_i | input | 32 | PC of the instruction |
| ex_tgt_i | input | 32 | Computed jump target |
| ret_fault_o | output | 1 | One-cycle return-address mismatch pulse |
| outer_lvl_o | output | 1 | High while in the outermost routine |
| stk_ovf_o | output | 1 | Sticky: a call found the shadow stack full |

## Verification
Every result is registered, so each output reflects the instruction sampled at the rising edge just before it. The fault pulse, the outermost-level flag and the overflow flag all appear one edge after the stimulus. The bench drives each instruction on a falling edge and compares the outputs on the next falling edge, one full cycle later, away from the active edge. After reset is released, the bench waits three cycles so that the two-stage reset synchronizer has let go before the first stimulus.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    CTI_NONE = 2'd0,
    CTI_CALL = 2'd1,
    CTI_RET  = 2'd2
  } cti_e;

  localparam logic [1:0] OP_CALL   = 2'b01;
  localparam logic [1:0] OP_ARITH  = 2'b10;
  localparam logic [5:0] OP3_JMPL  = 6'b111000;
  localparam logic [4:0] LINK_REG  = 5'd15;
endpackage

// File: rtl/rsc_rst_sync.sv
module rsc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/rsc_decode.sv
module rsc_decode
  import rsc_pkg::*;
(
  input  logic [31:0] insn_i,
  output cti_e        kind_o
);
  logic [1:0] op;
  logic [5:0] op3;
  logic [4:0] rd;
  logic       unused_bits;

  assign op          = insn_i[31:30];
  assign rd          = insn_i[29:25];
  assign op3         = insn_i[24:19];
  assign unused_bits = ^insn_i[18:0];

  // R2: classification of control transfers
  always_comb begin
    kind_o = CTI_NONE;
    if (op == OP_CALL) begin
      kind_o = CTI_CALL;
    end else if (op == OP_ARITH && op3 == OP3_JMPL) begin
      kind_o = (rd == LINK_REG) ? CTI_CALL : CTI_RET;
    end
  end
endmodule

// File: rtl/rsc_stack.sv
module rsc_stack #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] top_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [CNT_W-1:0]  top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;
  assign top_idx = empty_o ? '0 : cnt_q - CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (push_i)     cnt_d = cnt_q + CNT_W'(1);
    else if (pop_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic wr_en;
    assign wr_en = push_i && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk_i) begin
      if (wr_en) ent_q[g] <= push_data_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (top_idx == CNT_W'(i)) top_o = ent_q[i];
    end
  end

  // R8: occupancy never goes past the configured depth
  assert_depth_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R8: the control never pushes into a full stack
  assert_no_push_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o));
  // R9: the control never pops an empty stack
  assert_no_pop_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && empty_o));
  // R3: a push raises occupancy by one
  assert_push_grows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/retaddr_shadow_chk.sv
module retaddr_shadow_chk
  import rsc_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ADDR_W  = 32,
  parameter int RET_OFS = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       ex_insn_i,
  input  logic              ex_annul_i,
  input  logic [ADDR_W-1:0] ex_pc_i,
  input  logic [ADDR_W-1:0] ex_tgt_i,
  output logic              ret_fault_o,
  output logic              outer_lvl_o,
  output logic              stk_ovf_o
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(RET_OFS);

  logic              rst_n;
  cti_e              kind;
  logic              do_call, do_ret, push, pop;
  logic [ADDR_W-1:0] top;
  logic [CNT_W-1:0]  depth;
  logic              empty, full;
  logic              fault_d, fault_q;
  logic              ovf_d, ovf_q;
  logic              outer_d, outer_q;

  rsc_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  rsc_decode u_dec (
    .insn_i (ex_insn_i),
    .kind_o (kind)
  );

  assign do_call = !ex_annul_i && (kind == CTI_CALL);
  assign do_ret  = !ex_annul_i && (kind == CTI_RET);
  assign push    = do_call && !full;
  assign pop     = do_ret && !empty;

  rsc_stack #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (ex_pc_i),
    .top_o       (top),
    .count_o     (depth),
    .empty_o     (empty),
    .full_o      (full)
  );

  always_comb begin
    fault_d = do_ret && (empty || ((top + OFS) != ex_tgt_i));
    ovf_d   = ovf_q || (do_call && full);
    outer_d = outer_q;
    if (push && empty)                           outer_d = 1'b0;
    else if (pop && depth == CNT_W'(1))          outer_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      ovf_q   <= 1'b0;
      outer_q <= 1'b1;
    end else begin
      fault_q <= fault_d;
      ovf_q   <= ovf_d;
      outer_q <= outer_d;
    end
  end

  assign ret_fault_o = fault_q;
  assign stk_ovf_o   = ovf_q;
  assign outer_lvl_o = outer_q;

  // R5: a fault pulse only follows a live return
  assert_fault_after_ret_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ret_fault_o |-> $past(do_ret));
  // R8: overflow flag is sticky
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    stk_ovf_o |=> stk_ovf_o);
  // R6: annulled slots leave the stack alone
  assert_annul_inert_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ex_annul_i |=> $stable(depth));
  // R7: outermost level agrees with stack occupancy
  assert_outer_matches_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    outer_lvl_o == (depth == '0));
  // R9: an empty-stack return keeps the stack empty
  assert_empty_ret_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (do_ret && empty) |=> depth == '0);
endmodule

// File: tb/retaddr_shadow_chk_tb.sv
module retaddr_shadow_chk_tb;
  localparam int DEPTH = 16;
  localparam logic [31:0] I_NOP  = 32'h0100_0000;
  localparam logic [31:0] I_ADD  = 32'h8000_0000;
  localparam logic [31:0] I_CALL = 32'h4000_0010;
  localparam logic [31:0] I_JLNK = 32'h9FC0_0000;
  localparam logic [31:0] I_RET  = 32'h81C7_E008;

  typedef struct packed {
    logic [31:0] insn;
    logic        annul;
    logic [31:0] pc;
    logic [31:0] tgt;
    logic        exp_fault;
    logic        exp_outer;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{I_NOP,  1'b0, 32'h100, 32'h0,   1'b0, 1'b1},  // R2 non-CTI
    '{I_CALL, 1'b0, 32'h200, 32'h0,   1'b0, 1'b0},  // R3 R7
    '{I_RET,  1'b0, 32'h204, 32'h208, 1'b0, 1'b1},  // R4 R7
    '{I_JLNK, 1'b0, 32'h300, 32'h0,   1'b0, 1'b0},  // R2 rd=15 call
    '{I_CALL, 1'b0, 32'h400, 32'h0,   1'b0, 1'b0},  // R10 nest
    '{I_RET,  1'b0, 32'h404, 32'h408, 1'b0, 1'b0},  // R10 inner first
    '{I_RET,  1'b0, 32'h30c, 32'h999, 1'b1, 1'b1},  // R5 mismatch
    '{I_ADD,  1'b0, 32'h110, 32'h0,   1'b0, 1'b1},  // R2 other op=10
    '{I_CALL, 1'b1, 32'h500, 32'h0,   1'b0, 1'b1},  // R6 annulled call
    '{I_RET,  1'b1, 32'h504, 32'h1,   1'b0, 1'b1},  // R6 annulled return
    '{I_RET,  1'b0, 32'h508, 32'h50c, 1'b1, 1'b1},  // R9 empty return
    '{I_CALL, 1'b0, 32'h600, 32'h0,   1'b0, 1'b0},  // R3
    '{I_RET,  1'b0, 32'h604, 32'h600, 1'b1, 1'b1}   // R4 offset 8 required
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] ex_insn_i, ex_pc_i, ex_tgt_i;
  logic        ex_annul_i;
  logic        ret_fault_o, outer_lvl_o, stk_ovf_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk_i = ~clk_i;

  retaddr_shadow_chk #(.DEPTH(DEPTH)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ex_insn_i   (ex_insn_i),
    .ex_annul_i  (ex_annul_i),
    .ex_pc_i     (ex_pc_i),
    .ex_tgt_i    (ex_tgt_i),
    .ret_fault_o (ret_fault_o),
    .outer_lvl_o (outer_lvl_o),
    .stk_ovf_o   (stk_ovf_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] insn, input logic an,
                      input logic [31:0] pc, input logic [31:0] tgt);
    ex_insn_i  = insn;
    ex_annul_i = an;
    ex_pc_i    = pc;
    ex_tgt_i   = tgt;
    @(negedge clk_i);
    ex_insn_i  = I_NOP;
    ex_annul_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    ex_insn_i = I_NOP; ex_annul_i = 1'b0; ex_pc_i = '0; ex_tgt_i = '0;
    @(negedge clk_i);
    do_reset();
    // R1 reset state
    check("R1 fault", ret_fault_o, 1'b0);
    check("R1 outer", outer_lvl_o, 1'b1);
    check("R1 ovf",   stk_ovf_o,   1'b0);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v].insn, VEC[v].annul, VEC[v].pc, VEC[v].tgt);
      check($sformatf("R2-table row %0d fault", v), ret_fault_o, VEC[v].exp_fault);
      check($sformatf("R7 row %0d outer", v), outer_lvl_o, VEC[v].exp_outer);
      check($sformatf("R8 row %0d ovf", v), stk_ovf_o, 1'b0);
    end

    // R5 back-to-back faulting returns
    step(I_CALL, 1'b0, 32'h700, 32'h0);
    step(I_CALL, 1'b0, 32'h800, 32'h0);
    step(I_RET,  1'b0, 32'h804, 32'h1);
    check("R5 first pulse", ret_fault_o, 1'b1);
    step(I_RET,  1'b0, 32'h808, 32'h2);
    check("R5 second pulse", ret_fault_o, 1'b1);
    check("R7 back at outer", outer_lvl_o, 1'b1);
    step(I_NOP,  1'b0, 32'h80c, 32'h0);
    check("R5 pulse ends", ret_fault_o, 1'b0);

    // R8 overflow: fill, one more call, then unwind intact
    for (int i = 0; i < DEPTH; i++) step(I_CALL, 1'b0, 32'h1000 + 32'(i) * 16, 32'h0);
    check("R8 no ovf at full", stk_ovf_o, 1'b0);
    step(I_CALL, 1'b0, 32'hDEAD_0000, 32'h0);
    check("R8 ovf set", stk_ovf_o, 1'b1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      step(I_RET, 1'b0, 32'h2000, 32'h1000 + 32'(i) * 16 + 8);
      check($sformatf("R10 unwind %0d fault", i), ret_fault_o, 1'b0);
    end
    check("R7 outer after unwind", outer_lvl_o, 1'b1);
    check("R8 ovf sticky", stk_ovf_o, 1'b1);
    step(I_RET, 1'b0, 32'h2004, 32'h8);
    check("R9 empty after unwind", ret_fault_o, 1'b1);

    do_reset();
    check("R1 ovf cleared", stk_ovf_o, 1'b0);
    check("R1 outer after reset", outer_lvl_o, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule